// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Pinned Entries

This block is a small, fully associative translation cache. A lookup presents a page number, the current address-space tag and the kind of access wanted. Every entry is compared in parallel, and within the same cycle the block returns the frame number and the permission bits of the one matching entry. It also flags a permission fault when the access is not allowed. When nothing matches it raises a miss, so that an outside table walker can fetch the mapping and write it back in as a fill.

Each entry holds a page, a frame, an address-space tag, three permission bits (bit 0 read, bit 1 write, bit 2 execute), a global flag and a pinned flag. An entry with the global flag set matches under any tag. A pinned entry survives both kinds of bulk invalidation and is never chosen as a victim.

A fill is placed by these rules, in order of priority:
- It first reuses an entry that already holds the same key.
- Otherwise it takes the lowest-numbered empty entry.
- Otherwise a rotating pointer picks the first unpinned entry at or after its current position.

If every entry is pinned and no key matches, the fill is dropped and an error pulse is raised. Software can clear every unpinned entry, or only the entries that carry one tag and are neither global nor pinned.

Top module: `asid_tlb`

## Requirements
- R1: A lookup whose page equals a valid entry's page and whose tag equals that entry's tag drives `hit` high in the same cycle, together with the stored frame on `hitFrame` and the stored permissions on `hitPerm`.
- R2: A lookup that matches no valid entry drives `miss` high and `hit` low; a matching page under a different tag is a miss.
- R3: An entry filled with `fillGlobal` high matches a lookup of its page under any tag.
- R4: A fill with no key match goes to the lowest empty entry. When no entry is empty, it goes to the first unpinned entry at or after the rotating pointer, which starts at entry 0 after reset and then moves to one past the entry just replaced.
- R5: A pinned entry (filled with `fillWired` high) is never replaced by rotation and is never cleared by either invalidation command.
- R6: When every entry is pinned and no entry holds the fill's key, the fill is dropped, the contents are left unchanged, and `fillDropErr` is high for exactly the one cycle after the fill.
- R7: A fill whose page matches a valid entry whose tag is equal, or where either side is global, overwrites that entry and removes any other such entry, so a later lookup sees only the new frame. This applies to pinned entries as well.
- R8: `invAsidValid` clears, in one cycle, every entry whose tag equals `invAsid` and which is neither global nor pinned. Other entries stay valid.
- R9: `invAllValid` clears every unpinned entry, global ones included, in one cycle.
- R10: On a hit, `permFault` is high exactly when `lookupAccess` requests a bit (read bit 0, write bit 1, execute bit 2) that the entry's permissions lack.
- R11: A lookup in the same cycle as a fill sees the contents from before that fill. A fill issued in the same cycle as an invalidation survives it.
- R12: After reset no entry is valid, and every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupPage | input | PAGE_W | Page number to translate |
| lookupAsid | input | ASID_W | Current address-space tag |
| lookupAccess | input | 3 | Requested access: bit0 read, bit1 write, bit2 execute |
| hit | output | 1 | Lookup matched an entry |
| miss | output | 1 | Lookup matched no entry |
| permFault | output | 1 | Hit, but the requested access is not permitted |
| hitFrame | output | FRAME_W | Frame number of the matching entry |
| hitPerm | output | 3 | Permission bits of the matching entry |
| fillValid | input | 1 | Write a new translation |
| fillPage | input | PAGE_W | Page of the fill |
| fillAsid | input | ASID_W | Tag of the fill |
| fillFrame | input | FRAME_W | Frame of the fill |
| fillPerm | input | 3 | Permissions of the fill |
| fillGlobal | input | 1 | Fill matches under any tag |
| fillWired | input | 1 | Fill is pinned |
| fillDropErr | output | 1 | One-cycle pulse: previous fill found no slot |
| invAllValid | input | 1 | Clear all unpinned entries |
| invAsidValid | input | 1 | Clear unpinned, non-global entries with tag invAsid |
| invAsid | input | ASID_W | Tag for selective clear |

## Verification
Two pairs of functions can land in the same cycle: a lookup alongside a fill, and a fill alongside a bulk invalidation. The bench drives the first pair at one falling edge, with both the fill and the lookup for the same new key. It expects a miss in that cycle and a hit in the next. For the second pair it issues a fill together with a clear-all. It then expects the new key to hit while an older global entry and an older ordinary entry both miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int PERM_W   = 3;
  localparam int PERM_RD  = 0;
  localparam int PERM_WR  = 1;
  localparam int PERM_EX  = 2;

  // Strobes from the fill/victim control into the entry store.
  typedef struct packed {
    logic wrEn;     // write fill data into wrIdx
    logic clrAll;   // clear every unpinned entry
    logic clrAsid;  // clear unpinned non-global entries of one tag
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PAGE_W  = 20,
  parameter int FRAME_W = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobe_t         strb,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [PAGE_W-1:0]  fillPage,
  input  logic [ASID_W-1:0]  fillAsid,
  input  logic [FRAME_W-1:0] fillFrame,
  input  logic [PERM_W-1:0]  fillPerm,
  input  logic               fillGlobal,
  input  logic               fillWired,
  input  logic [ASID_W-1:0]  invAsid,
  input  logic [PAGE_W-1:0]  lookupPage,
  input  logic [ASID_W-1:0]  lookupAsid,
  output logic               hitAny,
  output logic [FRAME_W-1:0] hitFrame,
  output logic [PERM_W-1:0]  hitPerm,
  output logic [ENTRIES-1:0] dupVec,
  output logic [ENTRIES-1:0] freeVec,
  output logic [ENTRIES-1:0] wiredVec
);

  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] wiredQ;
  logic [ENTRIES-1:0] globalQ;
  logic [PAGE_W-1:0]  pageQ  [ENTRIES];
  logic [ASID_W-1:0]  asidQ  [ENTRIES];
  logic [FRAME_W-1:0] frameQ [ENTRIES];
  logic [PERM_W-1:0]  permQ  [ENTRIES];

  logic [ENTRIES-1:0] hitVec;

  // Parallel compare of every entry against the lookup key and the fill key.
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hitVec[g] = validQ[g] && (pageQ[g] == lookupPage) &&
                       (globalQ[g] || (asidQ[g] == lookupAsid));
    assign dupVec[g] = validQ[g] && (pageQ[g] == fillPage) &&
                       (globalQ[g] || fillGlobal || (asidQ[g] == fillAsid));
  end

  assign freeVec  = ~validQ;
  assign wiredVec = wiredQ;
  assign hitAny   = |hitVec;

  // At most one entry matches, so an OR of masked fields is the result.
  always_comb begin
    hitFrame = '0;
    hitPerm  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) begin
        hitFrame = hitFrame | frameQ[i];
        hitPerm  = hitPerm  | permQ[i];
      end
    end
  end

  // Valid and pinned flags: invalidations first, fill write last so it wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      wiredQ <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strb.clrAll && !wiredQ[i]) begin
          validQ[i] <= 1'b0;
        end
        if (strb.clrAsid && !wiredQ[i] && !globalQ[i] && (asidQ[i] == invAsid)) begin
          validQ[i] <= 1'b0;
        end
        if (strb.wrEn && dupVec[i] && (IDX_W'(i) != wrIdx)) begin
          validQ[i] <= 1'b0;
          wiredQ[i] <= 1'b0;
        end
        if (strb.wrEn && (IDX_W'(i) == wrIdx)) begin
          validQ[i] <= 1'b1;
          wiredQ[i] <= fillWired;
        end
      end
    end
  end

  // Payload storage carries no reset; validQ qualifies it.
  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      pageQ[wrIdx]   <= fillPage;
      asidQ[wrIdx]   <= fillAsid;
      frameQ[wrIdx]  <= fillFrame;
      permQ[wrIdx]   <= fillPerm;
      globalQ[wrIdx] <= fillGlobal;
    end
  end

  // Duplicate removal keeps lookups to a single match.
  assert_single_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // A pinned entry is always valid.
  assert_pinned_valid_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((wiredQ & ~validQ) == '0));

  // After a clear-all with no fill, only pinned entries remain.
  assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrAll && !strb.wrEn) |=> ((validQ & ~wiredQ) == '0));

endmodule

// File: rtl/tlb_fill_ctrl.sv
module tlb_fill_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  input  logic               invAllValid,
  input  logic               invAsidValid,
  input  logic [ENTRIES-1:0] dupVec,
  input  logic [ENTRIES-1:0] freeVec,
  input  logic [ENTRIES-1:0] wiredVec,
  output tlbStrobe_t         strb,
  output logic [IDX_W-1:0]   wrIdx,
  output logic               fillDropErr
);

  logic [IDX_W-1:0] rrPtr;
  logic             dupAny, freeAny, rrAny;
  logic [IDX_W-1:0] dupIdx, freeIdx, rrIdx;
  logic             dropNow;

  // Lowest matching key and lowest empty entry.
  always_comb begin
    dupAny  = 1'b0;
    dupIdx  = '0;
    freeAny = 1'b0;
    freeIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!dupAny && dupVec[i]) begin
        dupAny = 1'b1;
        dupIdx = IDX_W'(i);
      end
      if (!freeAny && freeVec[i]) begin
        freeAny = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  // First unpinned entry scanning forward from the rotating pointer.
  always_comb begin
    logic [IDX_W-1:0] pos;
    rrAny = 1'b0;
    rrIdx = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      pos = rrPtr + IDX_W'(k);
      if (!rrAny && !wiredVec[pos]) begin
        rrAny = 1'b1;
        rrIdx = pos;
      end
    end
  end

  always_comb begin
    strb.clrAll  = invAllValid;
    strb.clrAsid = invAsidValid;
    strb.wrEn    = fillValid && (dupAny || freeAny || rrAny);
    dropNow      = fillValid && !(dupAny || freeAny || rrAny);
    if (dupAny) begin
      wrIdx = dupIdx;
    end else if (freeAny) begin
      wrIdx = freeIdx;
    end else begin
      wrIdx = rrIdx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr       <= '0;
      fillDropErr <= 1'b0;
    end else begin
      fillDropErr <= dropNow;
      if (strb.wrEn && !dupAny && !freeAny) begin
        rrPtr <= rrIdx + IDX_W'(1);
      end
    end
  end

  // Rotation never lands on a pinned entry.
  assert_victim_unpinned_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !dupAny) |-> !wiredVec[wrIdx]);

  // A fill with every entry pinned and no key match raises the error next cycle.
  assert_drop_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && (&wiredVec) && !dupAny) |=> fillDropErr);

  // The error pulse only follows a fill.
  assert_drop_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    fillDropErr |-> $past(fillValid));

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PAGE_W  = 20,
  parameter int FRAME_W = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic [PAGE_W-1:0]  lookupPage,
  input  logic [ASID_W-1:0]  lookupAsid,
  input  logic [2:0]         lookupAccess,
  output logic               hit,
  output logic               miss,
  output logic               permFault,
  output logic [FRAME_W-1:0] hitFrame,
  output logic [2:0]         hitPerm,
  input  logic               fillValid,
  input  logic [PAGE_W-1:0]  fillPage,
  input  logic [ASID_W-1:0]  fillAsid,
  input  logic [FRAME_W-1:0] fillFrame,
  input  logic [2:0]         fillPerm,
  input  logic               fillGlobal,
  input  logic               fillWired,
  output logic               fillDropErr,
  input  logic               invAllValid,
  input  logic               invAsidValid,
  input  logic [ASID_W-1:0]  invAsid
);

  tlbStrobe_t         strb;
  logic [IDX_W-1:0]   wrIdx;
  logic [ENTRIES-1:0] dupVec, freeVec, wiredVec;
  logic               hitAny;

  tlb_entry_store #(
    .ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .ASID_W(ASID_W)
  ) u_store (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrIdx      (wrIdx),
    .fillPage   (fillPage),
    .fillAsid   (fillAsid),
    .fillFrame  (fillFrame),
    .fillPerm   (fillPerm),
    .fillGlobal (fillGlobal),
    .fillWired  (fillWired),
    .invAsid    (invAsid),
    .lookupPage (lookupPage),
    .lookupAsid (lookupAsid),
    .hitAny     (hitAny),
    .hitFrame   (hitFrame),
    .hitPerm    (hitPerm),
    .dupVec     (dupVec),
    .freeVec    (freeVec),
    .wiredVec   (wiredVec)
  );

  tlb_fill_ctrl #(
    .ENTRIES(ENTRIES)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .fillValid    (fillValid),
    .invAllValid  (invAllValid),
    .invAsidValid (invAsidValid),
    .dupVec       (dupVec),
    .freeVec      (freeVec),
    .wiredVec     (wiredVec),
    .strb         (strb),
    .wrIdx        (wrIdx),
    .fillDropErr  (fillDropErr)
  );

  assign hit       = lookupValid && hitAny;
  assign miss      = lookupValid && !hitAny;
  assign permFault = hit && ((lookupAccess & ~hitPerm) != 3'b000);

endmodule

// File: tb/asid_tlb_bench.sv
`timescale 1ns/1ps
module asid_tlb_bench;

  localparam int ENTRIES = 32;
  localparam int PAGE_W  = 20;
  localparam int FRAME_W = 20;
  localparam int ASID_W  = 8;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               lookupValid;
  logic [PAGE_W-1:0]  lookupPage;
  logic [ASID_W-1:0]  lookupAsid;
  logic [2:0]         lookupAccess;
  logic               hit, miss, permFault;
  logic [FRAME_W-1:0] hitFrame;
  logic [2:0]         hitPerm;
  logic               fillValid;
  logic [PAGE_W-1:0]  fillPage;
  logic [ASID_W-1:0]  fillAsid;
  logic [FRAME_W-1:0] fillFrame;
  logic [2:0]         fillPerm;
  logic               fillGlobal, fillWired;
  logic               fillDropErr;
  logic               invAllValid, invAsidValid;
  logic [ASID_W-1:0]  invAsid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    logic               expHit;
    logic [FRAME_W-1:0] expFrame;
    logic [2:0]         expPerm;
    logic               expFault;
    string              tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  asid_tlb #(
    .ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .ASID_W(ASID_W)
  ) u_asid_tlb (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupPage(lookupPage), .lookupAsid(lookupAsid),
    .lookupAccess(lookupAccess), .hit(hit), .miss(miss), .permFault(permFault),
    .hitFrame(hitFrame), .hitPerm(hitPerm),
    .fillValid(fillValid), .fillPage(fillPage), .fillAsid(fillAsid),
    .fillFrame(fillFrame), .fillPerm(fillPerm), .fillGlobal(fillGlobal),
    .fillWired(fillWired), .fillDropErr(fillDropErr),
    .invAllValid(invAllValid), .invAsidValid(invAsidValid), .invAsid(invAsid)
  );

  task automatic clearIn();
    lookupValid = 1'b0; lookupPage = '0; lookupAsid = '0; lookupAccess = 3'b000;
    fillValid = 1'b0; fillPage = '0; fillAsid = '0; fillFrame = '0;
    fillPerm = 3'b000; fillGlobal = 1'b0; fillWired = 1'b0;
    invAllValid = 1'b0; invAsidValid = 1'b0; invAsid = '0;
  endtask

  task automatic setFill(int page, int asid, int frame, logic [2:0] perm, logic glob, logic pin);
    fillValid  = 1'b1;
    fillPage   = PAGE_W'(page);
    fillAsid   = ASID_W'(asid);
    fillFrame  = FRAME_W'(frame);
    fillPerm   = perm;
    fillGlobal = glob;
    fillWired  = pin;
  endtask

  task automatic setLook(int page, int asid, logic [2:0] acc, logic eHit, int eFrame,
                         logic [2:0] ePerm, logic eFault, string tag);
    expItem_t it;
    lookupValid  = 1'b1;
    lookupPage   = PAGE_W'(page);
    lookupAsid   = ASID_W'(asid);
    lookupAccess = acc;
    it.expHit = eHit; it.expFrame = FRAME_W'(eFrame); it.expPerm = ePerm;
    it.expFault = eFault; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic doReset();
    @(negedge clk);
    clearIn();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic fill(int page, int asid, int frame, logic [2:0] perm, logic glob, logic pin);
    @(negedge clk);
    clearIn();
    setFill(page, asid, frame, perm, glob, pin);
  endtask

  task automatic look(int page, int asid, logic [2:0] acc, logic eHit, int eFrame,
                      logic [2:0] ePerm, logic eFault, string tag);
    @(negedge clk);
    clearIn();
    setLook(page, asid, acc, eHit, eFrame, ePerm, eFault, tag);
  endtask

  task automatic checkDrop(logic exp, string tag);
    @(negedge clk);
    clearIn();
    #1;
    total++;
    if (fillDropErr !== exp) begin
      bad++;
      $display("FAIL %s: fillDropErr=%0b expected=%0b", tag, fillDropErr, exp);
    end
  endtask

  // Monitor: pops one expected item per lookup cycle and compares.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() != 0) begin
        expItem_t it;
        it = expQ.pop_front();
        total++;
        if (hit !== it.expHit || miss !== !it.expHit ||
            (it.expHit && (hitFrame !== it.expFrame || hitPerm !== it.expPerm ||
                           permFault !== it.expFault))) begin
          bad++;
          $display("FAIL %s: hit=%0b miss=%0b frame=%h perm=%b fault=%0b expected hit=%0b frame=%h perm=%b fault=%0b",
                   it.tag, hit, miss, hitFrame, hitPerm, permFault,
                   it.expHit, it.expFrame, it.expPerm, it.expFault);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clearIn();
    doReset();

    // R12: nothing valid after reset
    look('h5, 1, 3'b001, 0, 0, 0, 0, "R12 reset empty");

    // R1, R2, R10
    fill('h10, 1, 'hA1, 3'b011, 0, 0);
    look('h10, 1, 3'b001, 1, 'hA1, 3'b011, 0, "R1 basic hit");
    look('h10, 2, 3'b001, 0, 0, 0, 0, "R2 other tag misses");
    look('h11, 1, 3'b001, 0, 0, 0, 0, "R2 other page misses");
    look('h10, 1, 3'b100, 1, 'hA1, 3'b011, 1, "R10 execute fault");
    look('h10, 1, 3'b010, 1, 'hA1, 3'b011, 0, "R10 write allowed");

    // R3: global entry under any tag
    fill('h20, 1, 'hB2, 3'b111, 1, 0);
    look('h20, 7, 3'b111, 1, 'hB2, 3'b111, 0, "R3 global any tag");

    // R7: same key overwrites
    fill('h10, 1, 'hC3, 3'b101, 0, 0);
    look('h10, 1, 3'b010, 1, 'hC3, 3'b101, 1, "R7 overwrite same key");

    // R8: invalidate by tag
    fill('h30, 2, 'hD4, 3'b001, 0, 0);
    fill('h40, 1, 'hE5, 3'b001, 0, 0);
    @(negedge clk); clearIn(); invAsidValid = 1'b1; invAsid = 8'd1;
    look('h40, 1, 3'b001, 0, 0, 0, 0, "R8 tag entry cleared");
    look('h10, 1, 3'b001, 0, 0, 0, 0, "R8 second tag entry cleared");
    look('h20, 1, 3'b001, 1, 'hB2, 3'b111, 0, "R8 global kept");
    look('h30, 2, 3'b001, 1, 'hD4, 3'b001, 0, "R8 other tag kept");

    // R11: lookup with fill in the same cycle sees old contents
    @(negedge clk); clearIn();
    setFill('h50, 3, 'hF6, 3'b001, 0, 0);
    setLook('h50, 3, 3'b001, 0, 0, 0, 0, "R11 same-cycle lookup sees old");
    look('h50, 3, 3'b001, 1, 'hF6, 3'b001, 0, "R11 fill visible next cycle");

    // R11 / R9: fill with clear-all in the same cycle survives
    @(negedge clk); clearIn();
    setFill('h60, 3, 'h66, 3'b011, 0, 0);
    invAllValid = 1'b1;
    look('h60, 3, 3'b001, 1, 'h66, 3'b011, 0, "R11 fill survives clear-all");
    look('h50, 3, 3'b001, 0, 0, 0, 0, "R9 ordinary entry cleared");
    look('h20, 1, 3'b001, 0, 0, 0, 0, "R9 global entry cleared");

    // R4, R5: rotation skips pinned entries
    doReset();
    for (int k = 0; k < ENTRIES; k++) begin
      fill('h100 + k, 1, 'h200 + k, 3'b011, 0, (k < 2) ? 1'b1 : 1'b0);
    end
    fill('h180, 1, 'h280, 3'b011, 0, 0);
    checkDrop(1'b0, "R6 no error on normal fill");
    look('h102, 1, 3'b001, 0, 0, 0, 0, "R4 first unpinned entry replaced");
    look('h180, 1, 3'b001, 1, 'h280, 3'b011, 0, "R4 new entry present");
    look('h100, 1, 3'b001, 1, 'h200, 3'b011, 0, "R5 pinned entry kept");
    look('h103, 1, 3'b001, 1, 'h203, 3'b011, 0, "R4 next entry still present");
    fill('h181, 1, 'h281, 3'b011, 0, 0);
    look('h103, 1, 3'b001, 0, 0, 0, 0, "R4 pointer advanced");
    look('h104, 1, 3'b001, 1, 'h204, 3'b011, 0, "R4 following entry kept");
    @(negedge clk); clearIn(); invAllValid = 1'b1;
    look('h101, 1, 3'b001, 1, 'h201, 3'b011, 0, "R5 pinned survives clear-all");
    look('h181, 1, 3'b001, 0, 0, 0, 0, "R9 unpinned cleared");

    // R6: every entry pinned
    doReset();
    for (int k = 0; k < ENTRIES; k++) begin
      fill('h300 + k, 2, 'h400 + k, 3'b001, 0, 1);
    end
    fill('h3FF, 2, 'h4FF, 3'b001, 0, 0);
    checkDrop(1'b1, "R6 drop flagged");
    checkDrop(1'b0, "R6 flag is one cycle");
    look('h3FF, 2, 3'b001, 0, 0, 0, 0, "R6 dropped fill absent");
    look('h300, 2, 3'b001, 1, 'h400, 3'b001, 0, "R6 contents unchanged");
    look('h31F, 2, 3'b001, 1, 'h41F, 3'b001, 0, "R6 last entry unchanged");
    fill('h305, 2, 'h999, 3'b111, 0, 1);
    checkDrop(1'b0, "R7 overwrite of pinned key allowed");
    look('h305, 2, 3'b100, 1, 'h999, 3'b111, 0, "R7 pinned key rewritten");

    @(negedge clk); clearIn();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule